// File: doc/BRIEF.md
# Priority Interrupt Routing Register

This block is an 8-bit control register that steers one active-high interrupt request, coming from a network controller core, to a single destination. There are three possible destinations. The first two are the microcontroller's two active-low interrupt inputs, and these are shared with other sources by wired-AND. The third is one of eight general-purpose port pins, which an external interrupt controller watches.

Software writes the register to enable one or more routes. When more than one route is enabled, a fixed priority picks exactly one winner. A 3-bit binary field chooses the port pin used by the external route. A separate bit requests the doubled core clock for the high data rate. That bit goes out as a rate-select signal, and a warning output is raised while it is set without the slow-arbitration setup bit.

The routing outputs are registered. A change on the interrupt input or in the configuration reaches the pins one clock later.

Top module: `irq_steer_reg`

## Requirements
- R1: After reset the register reads 0x00, both interrupt pins are high, no port pin is overridden (enable and value vectors are 0), and the rate and warning outputs are 0.
- R2: A write stores bits 6..0 on the next clock edge, and a read returns them unchanged. Bit 7 always reads 0 and ignores writes.
- R3: With bit 0 set and winning, `mcu_int0_n` is low exactly while the core interrupt was high one cycle earlier, and high otherwise.
- R4: With bit 1 set and winning, `mcu_int1_n` is low exactly while the core interrupt was high one cycle earlier, and high otherwise.
- R5: With bit 2 set and winning, the override enable is set only on the port pin whose index is the binary value of bits 5..3 (000 selects pin 0, 111 selects pin 7). That pin's override value is 1 while the interrupt is high and 0 while it is low.
- R6: Priority is bit 0, then bit 1, then bit 2. At most one destination is ever active, and a losing route drives nothing.
- R7: Port pins that are not selected, and the selected pin when the external route does not win, report no override, and an interrupt pin that is not routed stays high.
- R8: The routing outputs change one clock edge after the core interrupt input changes, and one edge after the register has taken a new value.
- R9: `rate_double` follows bit 6 of the stored register, so it changes on the same edge as the write.
- R10: `rate_unsafe` is high exactly when bit 6 is set and `slow_arb_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| core_irq | input | 1 | Active-high interrupt from the network core |
| slow_arb_on | input | 1 | Slow-arbitration setup bit from another register |
| mcu_int0_n | output | 1 | Active-low interrupt input 0 (pull-low only) |
| mcu_int1_n | output | 1 | Active-low interrupt input 1 (pull-low only) |
| port_ovr_en | output | 8 | Per-pin port override enable |
| port_ovr_val | output | 8 | Per-pin port override level |
| rate_double | output | 1 | Request for the doubled core clock |
| rate_unsafe | output | 1 | Rate bit set while slow arbitration is off |

## Verification
The register contents and the two rate outputs are due on the first edge after a write, so the bench reads them at the falling edge that follows the write. Every pin output is due one edge later than its cause: one edge after the register has changed, or one edge after the interrupt input has changed. The bench therefore samples the pins at the next falling edge. The latency test also samples once early, at the point where the pins must still show the old routing.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_INT0 = 2'd1,
      ROUTE_INT1 = 2'd2,
      ROUTE_EXT  = 2'd3
   } route_e;
endpackage

// File: rtl/irq_steer_regfile.sv
module irq_steer_regfile #(
   parameter int REG_W  = 8,
   parameter int LIVE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);
   localparam logic [REG_W-1:0] LIVE_MASK = REG_W'((1 << LIVE_W) - 1);

   initial begin
      if (LIVE_W > REG_W) $error("live width exceeds register width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & LIVE_MASK;
   end
endmodule

// File: rtl/irq_steer_arb.sv
module irq_steer_arb
   import irq_steer_pkg::*;
(
   input  logic   en_int0,
   input  logic   en_int1,
   input  logic   en_ext,
   output route_e route
);
   always_comb begin
      if (en_int0)      route = ROUTE_INT0;
      else if (en_int1) route = ROUTE_INT1;
      else if (en_ext)  route = ROUTE_EXT;
      else              route = ROUTE_NONE;
   end
endmodule

// File: rtl/irq_steer_drive.sv
module irq_steer_drive
   import irq_steer_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int SEL_W       = 3,
   parameter bit EXT_ACT_LOW = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq,
   input  route_e          route,
   input  logic [SEL_W-1:0] sel,
   output logic            int0_n,
   output logic            int1_n,
   output logic [PINS-1:0] ovr_en,
   output logic [PINS-1:0] ovr_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int0_n <= 1'b1;
         int1_n <= 1'b1;
      end else begin
         int0_n <= !(irq && route == ROUTE_INT0);
         int1_n <= !(irq && route == ROUTE_INT1);
      end
   end

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic hit;
      assign hit = (route == ROUTE_EXT) && (sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ovr_en[i] <= 1'b0;
         else        ovr_en[i] <= hit;
      end

      if (EXT_ACT_LOW) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovr_val[i] <= 1'b1;
            else        ovr_val[i] <= !(hit && irq);
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovr_val[i] <= 1'b0;
            else        ovr_val[i] <= hit && irq;
         end
      end
   end
endmodule

// File: rtl/irq_steer_reg.sv
module irq_steer_reg
   import irq_steer_pkg::*;
#(
   parameter int PORT_PINS   = 8,
   parameter int REG_W       = 8,
   parameter bit EXT_ACT_LOW = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic                 core_irq,
   input  logic                 slow_arb_on,
   output logic                 mcu_int0_n,
   output logic                 mcu_int1_n,
   output logic [PORT_PINS-1:0] port_ovr_en,
   output logic [PORT_PINS-1:0] port_ovr_val,
   output logic                 rate_double,
   output logic                 rate_unsafe
);
   localparam int SEL_W    = (PORT_PINS > 1) ? $clog2(PORT_PINS) : 1;
   localparam int B_INT0   = 0;
   localparam int B_INT1   = 1;
   localparam int B_EXT    = 2;
   localparam int B_SEL_LO = 3;
   localparam int B_RATE   = B_SEL_LO + SEL_W;
   localparam int LIVE_W   = B_RATE + 1;

   initial begin
      if (PORT_PINS != (1 << SEL_W)) $error("PORT_PINS must be a power of two");
      if (REG_W < LIVE_W)            $error("REG_W too narrow for the field layout");
   end

   logic [REG_W-1:0] cfg_q;
   route_e           route;

   irq_steer_regfile #(.REG_W(REG_W), .LIVE_W(LIVE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .q(cfg_q)
   );

   irq_steer_arb u_arb (
      .en_int0(cfg_q[B_INT0]), .en_int1(cfg_q[B_INT1]), .en_ext(cfg_q[B_EXT]),
      .route(route)
   );

   irq_steer_drive #(.PINS(PORT_PINS), .SEL_W(SEL_W), .EXT_ACT_LOW(EXT_ACT_LOW)) u_drive (
      .clk(clk), .rst_n(rst_n), .irq(core_irq), .route(route),
      .sel(cfg_q[B_SEL_LO +: SEL_W]),
      .int0_n(mcu_int0_n), .int1_n(mcu_int1_n),
      .ovr_en(port_ovr_en), .ovr_val(port_ovr_val)
   );

   assign reg_rdata   = cfg_q;
   assign rate_double = cfg_q[B_RATE];
   assign rate_unsafe = cfg_q[B_RATE] & ~slow_arb_on;
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
   parameter int PORT_PINS = 8,
   parameter int REG_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [REG_W-1:0]     reg_wdata,
   input logic [REG_W-1:0]     reg_rdata,
   input logic                 core_irq,
   input logic                 mcu_int0_n,
   input logic                 mcu_int1_n,
   input logic [PORT_PINS-1:0] port_ovr_en,
   input logic                 rate_double
);
   // R2
   top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1] == 1'b0);

   // R3
   int0_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mcu_int0_n |-> $past(core_irq));

   // R6
   single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~mcu_int0_n, ~mcu_int1_n, |port_ovr_en}));

   // R7
   one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_ovr_en));

   // R8
   int0_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_irq && reg_rdata[0] && !reg_we) |=> !mcu_int0_n);

   // R9
   rate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> rate_double == $past(reg_wdata[6]));
endmodule

bind irq_steer_reg irq_steer_chk #(.PORT_PINS(PORT_PINS), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .core_irq(core_irq), .mcu_int0_n(mcu_int0_n),
   .mcu_int1_n(mcu_int1_n), .port_ovr_en(port_ovr_en), .rate_double(rate_double)
);

// File: tb/test_irq_steer_reg.sv
module test_irq_steer_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       core_irq = 1'b0;
   logic       slow_arb_on = 1'b0;
   logic       mcu_int0_n, mcu_int1_n, rate_double, rate_unsafe;
   logic [7:0] port_ovr_en, port_ovr_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_steer_reg i_irq_steer_reg (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .core_irq(core_irq), .slow_arb_on(slow_arb_on),
      .mcu_int0_n(mcu_int0_n), .mcu_int1_n(mcu_int1_n),
      .port_ovr_en(port_ovr_en), .port_ovr_val(port_ovr_val),
      .rate_double(rate_double), .rate_unsafe(rate_unsafe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Write lands on the posedge; returns at the following negedge.
   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_irq(input logic v);
      core_irq = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 rdata", reg_rdata, 0);
      check("R1 int0", mcu_int0_n, 1);
      check("R1 int1", mcu_int1_n, 1);
      check("R1 ovr_en", port_ovr_en, 0);
      check("R1 ovr_val", port_ovr_val, 0);
      check("R1 rate", {rate_double, rate_unsafe}, 0);
   endtask

   task automatic t_readback;
      wr(8'hFF); check("R2 top bit masked", reg_rdata, 8'h7F);
      wr(8'h5A); check("R2 pattern", reg_rdata, 8'h5A);
      wr(8'h80); check("R2 bit7 ignored", reg_rdata, 8'h00);
      wr(8'h00);
   endtask

   task automatic t_int0;
      wr(8'h01); @(negedge clk);
      set_irq(1'b1);
      check("R3 int0 low", mcu_int0_n, 0);
      check("R7 int1 idle", mcu_int1_n, 1);
      check("R7 no ovr", port_ovr_en, 0);
      set_irq(1'b0);
      check("R3 int0 release", mcu_int0_n, 1);
   endtask

   task automatic t_int1;
      wr(8'h02); @(negedge clk);
      set_irq(1'b1);
      check("R4 int1 low", mcu_int1_n, 0);
      check("R7 int0 idle", mcu_int0_n, 1);
      set_irq(1'b0);
      check("R4 int1 release", mcu_int1_n, 1);
   endtask

   task automatic t_ext;
      for (int s = 0; s < 8; s++) begin
         wr(8'(s << 3) | 8'h04); @(negedge clk);
         check("R5 idle en", port_ovr_en, 32'(1 << s));
         check("R5 idle val", port_ovr_val, 0);
         set_irq(1'b1);
         check("R5 sel en", port_ovr_en, 32'(1 << s));
         check("R5 sel val", port_ovr_val, 32'(1 << s));
         check("R7 int pins idle", {mcu_int0_n, mcu_int1_n}, 2'b11);
         set_irq(1'b0);
      end
   endtask

   task automatic t_prio;
      core_irq = 1'b1;
      wr(8'h3F); @(negedge clk);
      check("R6 all set int0 wins", {mcu_int0_n, mcu_int1_n}, 2'b01);
      check("R6 all set no ovr", port_ovr_en, 0);
      wr(8'h3E); @(negedge clk);
      check("R6 int1 over ext", {mcu_int0_n, mcu_int1_n}, 2'b10);
      check("R6 int1 over ext ovr", port_ovr_en, 0);
      wr(8'h05); @(negedge clk);
      check("R6 int0 over ext", {mcu_int0_n, mcu_int1_n}, 2'b01);
      check("R6 int0 over ext ovr", port_ovr_en, 0);
      set_irq(1'b0);
   endtask

   task automatic t_latency;
      wr(8'h00); @(negedge clk);
      core_irq = 1'b1;
      wr(8'h02);
      check("R8 config not yet at pin", mcu_int1_n, 1);
      @(negedge clk);
      check("R8 config at pin", mcu_int1_n, 0);
      core_irq = 1'b0;
      check("R8 irq drop not yet at pin", mcu_int1_n, 0);
      @(negedge clk);
      check("R8 irq drop at pin", mcu_int1_n, 1);
   endtask

   task automatic t_rate;
      slow_arb_on = 1'b0;
      wr(8'h40);
      check("R9 rate set", rate_double, 1);
      check("R10 unsafe", rate_unsafe, 1);
      slow_arb_on = 1'b1; #1;
      check("R10 safe", rate_unsafe, 0);
      wr(8'h00);
      check("R9 rate clear", rate_double, 0);
      slow_arb_on = 1'b0; #1;
      check("R10 no rate no warn", rate_unsafe, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_readback;
      t_int0;
      t_int1;
      t_ext;
      t_prio;
      t_latency;
      t_rate;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule